// File: doc/BRIEF.md
# Multi-mode 8x8 Hardware Multiplier

This unit multiplies two 8-bit register operands for a small processor core. It returns the 16-bit product as a high byte and a low byte, together with a carry flag and a zero flag. A 3-bit mode selects how the operands are read. Each operand can be unsigned or two's-complement signed, with a mixed form in which operand A is signed and operand B is unsigned. Each of these readings also has a fractional variant. In a fractional mode, 1.7-format inputs give a 1.15-format result: the raw product is moved one place to the left, and the bit that leaves the top is reported as carry.

The core pulses `start` together with the mode and both operands. Every multiply takes the same number of cycles. A one-cycle `done` pulse marks the cycle in which the result and flags become valid, and they keep their values until the next `done`. A `start` that arrives while a multiply is in flight is dropped. Instruction decode and register-file access are handled by the surrounding core.

Top module: `mmul_unit`

## Requirements
- R1: Mode 0 (unsigned by unsigned) gives {prod_hi,prod_lo} = A*B, with both operands read as 0..255.
- R2: Mode 1 (signed by signed) gives the 16-bit two's-complement product, with both operands read as -128..127.
- R3: Mode 2 (mixed) reads A as signed and B as unsigned, and gives the 16-bit two's-complement product.
- R4: Modes 4, 5 and 6 form the same raw product as modes 0, 1 and 2. The result is that raw product shifted left by one bit and truncated to 16 bits. prod_hi holds bits 15..8 and prod_lo holds bits 7..0.
- R5: carry equals bit 15 of the raw product before any fractional shift. In integer modes it therefore equals prod_hi bit 7.
- R6: zero is 1 exactly when the final 16-bit result is 0x0000.
- R7: In mode 5, 0x80 times 0x80 (-1 times -1) wraps to 0x8000 with carry 0 and zero 0.
- R8: A start that is accepted at rising edge k makes done high for exactly one cycle, beginning at edge k+2. Results and flags are valid in that same cycle.
- R9: A start that is sampled at edge k+1 or k+2 after an accepted start is ignored. A start at edge k+3 is accepted. At most one multiply is in flight.
- R10: prod_hi, prod_lo, carry and zero hold their values in every cycle in which done is low.
- R11: The reserved mode codes 3 and 7 behave as codes 0 and 4 (unsigned).
- R12: While rst_n is low at a rising edge, done, prod_hi, prod_lo, carry and zero are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a multiply with the current mode and operands |
| mode | input | 3 | Bit 2 selects fractional; bits 1..0 select sign handling: 0 unsigned, 1 signed, 2 A signed and B unsigned, 3 unsigned |
| opa | input | 8 | Operand A |
| opb | input | 8 | Operand B |
| done | output | 1 | One-cycle pulse when the result is valid |
| prod_hi | output | 8 | Result bits 15..8 |
| prod_lo | output | 8 | Result bits 7..0 |
| carry | output | 1 | Bit 15 of the raw product before the fractional shift |
| zero | output | 1 | Final result equals zero |

## Verification
The assertions check on every cycle the following properties: the latency from an accepted start to done, that done lasts one cycle, that at most one multiply is in flight, that results hold between done pulses, that carry matches the top result bit in integer modes, and that the -1 by -1 fractional case wraps. The numeric results of each mode cannot be checked by an assertion. Only the scoreboard scenarios show them: operand sweeps against an independent model, the mixed-sign reading, the reserved codes, and back-to-back starts in which the middle requests must vanish.

// File: rtl/mmul_pkg.sv
// mmul_pkg: mode decoding shared by the multiplier modules.
// Assumes mode bit 2 selects fractional and bits 1..0 select sign handling.
package mmul_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [1:0] {
        SGN_UU  = 2'd0,
        SGN_SS  = 2'd1,
        SGN_SU  = 2'd2,
        SGN_RSV = 2'd3
    } sign_kind_e;

    // Operand A is read as signed in signed and mixed modes.
    function automatic logic first_is_signed(input logic [MODE_W-1:0] m);
        return (sign_kind_e'(m[1:0]) == SGN_SS) || (sign_kind_e'(m[1:0]) == SGN_SU);
    endfunction

    // Operand B is read as signed only in signed mode.
    function automatic logic second_is_signed(input logic [MODE_W-1:0] m);
        return sign_kind_e'(m[1:0]) == SGN_SS;
    endfunction

    // True in the fractional modes.
    function automatic logic is_fractional(input logic [MODE_W-1:0] m);
        return m[MODE_W-1];
    endfunction

endpackage

// File: rtl/mmul_opnd_ext.sv
// mmul_opnd_ext: captures one operand on an accepted start and widens it
// by one bit. The new top bit is the sign bit or zero, as the mode requires.
// Assumes load is asserted only when the controller accepts a start.
module mmul_opnd_ext
    import mmul_pkg::*;
#(
    parameter int W        = 8,
    parameter bit IS_FIRST = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [MODE_W-1:0]   mode,
    input  logic [W-1:0]        opnd,
    output logic signed [W:0]   ext_q
);

    logic sgn;

    // Pick the sign rule that matches this operand position.
    generate
        if (IS_FIRST) begin : g_first
            assign sgn = first_is_signed(mode);
        end else begin : g_second
            assign sgn = second_is_signed(mode);
        end
    endgenerate

    // Register the widened operand when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_q <= '0;
        end else if (load) begin
            ext_q <= {sgn & opnd[W-1], opnd};
        end
    end

endmodule

// File: rtl/mmul_ctrl.sv
// mmul_ctrl: fixed-latency sequencer. It accepts a start only when idle,
// moves a valid token through two stages and pulses done once.
// Assumes the datapath uses stg1_v and stg2_v as its stage enables.
module mmul_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic accept,
    output logic stg1_v,
    output logic stg2_v,
    output logic done
);

    logic busy;

    assign busy   = stg1_v | stg2_v;
    assign accept = start & ~busy;

    // Advance the single in-flight token.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg1_v <= 1'b0;
            stg2_v <= 1'b0;
            done   <= 1'b0;
        end else begin
            stg1_v <= accept;
            stg2_v <= stg1_v;
            done   <= stg2_v;
        end
    end

    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |-> ##3 done); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({stg1_v, stg2_v, done})); // R9

endmodule

// File: rtl/mmul_datapath.sv
// mmul_datapath: multiplies the widened operands, applies the fractional
// realignment and derives the flags. Outputs change only when stg2_v is high.
// Assumes the operands are already registered and widened by one bit.
module mmul_datapath
    import mmul_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                accept,
    input  logic                stg1_v,
    input  logic                stg2_v,
    input  logic [MODE_W-1:0]   mode,
    input  logic signed [W:0]   a_x,
    input  logic signed [W:0]   b_x,
    output logic [2*W-1:0]      res_q,
    output logic                carry_q,
    output logic                zero_q
);

    localparam int PW = 2 * W;
    localparam logic signed [W:0]  XMIN   = {2'b11, {(W-1){1'b0}}};
    localparam logic [PW-1:0]      WRAPPED = {1'b1, {(PW-1){1'b0}}};

    logic                   frac_s1;
    logic                   frac_s2;
    logic signed [PW+1:0]   full;
    logic [PW-1:0]          raw_q;
    logic [PW-1:0]          res_d;

    assign full  = a_x * b_x;
    assign res_d = frac_s2 ? {raw_q[PW-2:0], 1'b0} : raw_q;

    // Hold the fractional selector alongside the operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frac_s1 <= 1'b0;
        end else if (accept) begin
            frac_s1 <= is_fractional(mode);
        end
    end

    // Register the raw product of the widened operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q   <= '0;
            frac_s2 <= 1'b0;
        end else if (stg1_v) begin
            raw_q   <= full[PW-1:0];
            frac_s2 <= frac_s1;
        end
    end

    // Align, flag and publish the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q   <= '0;
            carry_q <= 1'b0;
            zero_q  <= 1'b0;
        end else if (stg2_v) begin
            res_q   <= res_d;
            carry_q <= raw_q[PW-1];
            zero_q  <= (res_d == '0);
        end
    end

    AST_CARRY_INTEGER: assert property (@(posedge clk) disable iff (!rst_n)
        (stg2_v && !frac_s2) |=> (carry_q == res_q[PW-1])); // R5

    AST_FRAC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (stg1_v && frac_s1 && a_x == XMIN && b_x == XMIN) |-> ##2 (res_q == WRAPPED && !carry_q && !zero_q)); // R7

endmodule

// File: rtl/mmul_unit.sv
// mmul_unit: top level of the multi-mode multiplier. It wires the
// controller, the two operand extenders and the datapath, and splits the
// result into bytes. Assumes start is sampled together with mode and operands.
module mmul_unit
    import mmul_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [MODE_W-1:0]   mode,
    input  logic [W-1:0]        opa,
    input  logic [W-1:0]        opb,
    output logic                done,
    output logic [W-1:0]        prod_hi,
    output logic [W-1:0]        prod_lo,
    output logic                carry,
    output logic                zero
);

    localparam int PW = 2 * W;

    logic                accept;
    logic                stg1_v;
    logic                stg2_v;
    logic signed [W:0]   a_x;
    logic signed [W:0]   b_x;
    logic [PW-1:0]       res;

    mmul_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .accept (accept),
        .stg1_v (stg1_v),
        .stg2_v (stg2_v),
        .done   (done)
    );

    mmul_opnd_ext #(.W(W), .IS_FIRST(1'b1)) u_ext_a (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .mode  (mode),
        .opnd  (opa),
        .ext_q (a_x)
    );

    mmul_opnd_ext #(.W(W), .IS_FIRST(1'b0)) u_ext_b (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .mode  (mode),
        .opnd  (opb),
        .ext_q (b_x)
    );

    mmul_datapath #(.W(W)) u_dp (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .stg1_v  (stg1_v),
        .stg2_v  (stg2_v),
        .mode    (mode),
        .a_x     (a_x),
        .b_x     (b_x),
        .res_q   (res),
        .carry_q (carry),
        .zero_q  (zero)
    );

    assign prod_hi = res[PW-1:W];
    assign prod_lo = res[W-1:0];

    // Track that a reset has been seen, so that the history check is valid.
    logic seen_rst;
    logic past_ok;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_rst <= 1'b1;
            past_ok  <= 1'b0;
        end else begin
            past_ok  <= seen_rst;
        end
    end

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        !done |-> $stable({prod_hi, prod_lo, carry, zero})); // R10

endmodule

// File: tb/tb_mmul_unit.sv
`timescale 1ns/1ps
module tb_mmul_unit;

    typedef struct {
        logic [15:0] res;
        logic        c;
        logic        z;
        int          issue_cyc;
        string       tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [2:0] mode = 3'd0;
    logic [7:0] opa = 8'd0;
    logic [7:0] opb = 8'd0;
    logic       done;
    logic [7:0] prod_hi;
    logic [7:0] prod_lo;
    logic       carry;
    logic       zero;

    int   n_checks = 0;
    int   n_fails  = 0;
    int   cyc      = 0;
    bit   mon_on   = 1'b0;
    exp_t sb[$];
    logic [17:0] last_out = '0;

    mmul_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .opa(opa), .opb(opb), .done(done), .prod_hi(prod_hi),
        .prod_lo(prod_lo), .carry(carry), .zero(zero)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Independent model: {result[15:0], carry, zero}.
    function automatic logic [17:0] model(input logic [2:0] m, input logic [7:0] a, input logic [7:0] b);
        int av, bv, p;
        logic [15:0] raw, r;
        av = int'(a);
        bv = int'(b);
        if ((m[1:0] == 2'd1 || m[1:0] == 2'd2) && a[7]) av = av - 256;
        if (m[1:0] == 2'd1 && b[7]) bv = bv - 256;
        p   = av * bv;
        raw = p[15:0];
        r   = m[2] ? {raw[14:0], 1'b0} : raw;
        return {r, raw[15], (r == 16'h0000)};
    endfunction

    function automatic string mode_tag(input logic [2:0] m);
        if (m == 3'd3 || m == 3'd7) return "R11";
        if (m[2]) return "R4";
        if (m[1:0] == 2'd1) return "R2";
        if (m[1:0] == 2'd2) return "R3";
        return "R1";
    endfunction

    // Drive one request at the current (negedge) time; optionally score it.
    task automatic drive(input logic [2:0] m, input logic [7:0] a, input logic [7:0] b, input bit push, input string tag);
        exp_t e;
        logic [17:0] v;
        start = 1'b1;
        mode  = m;
        opa   = a;
        opb   = b;
        if (push) begin
            v = model(m, a, b);
            e.res = v[17:2];
            e.c = v[1];
            e.z = v[0];
            e.issue_cyc = cyc;
            e.tag = tag;
            sb.push_back(e);
        end
    endtask

    // One multiply at full throughput: the next call starts at edge k+3.
    task automatic single(input logic [2:0] m, input logic [7:0] a, input logic [7:0] b, input string tag);
        @(negedge clk);
        drive(m, a, b, 1'b1, tag);
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
    endtask

    // Scoreboard monitor: compares on done, checks hold otherwise.
    always @(negedge clk) begin
        if (mon_on) begin
            if (done) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R9 unexpected done", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk({prod_hi, prod_lo} == e.res, e.tag, {prod_hi, prod_lo}, e.res);
                    chk(carry == e.c, "R5 carry", carry, e.c);
                    chk(zero == e.z, "R6 zero", zero, e.z);
                    chk(cyc == e.issue_cyc + 3, "R8 latency", cyc - e.issue_cyc, 3);
                end
                last_out = {prod_hi, prod_lo, carry, zero};
            end else begin
                chk({prod_hi, prod_lo, carry, zero} == last_out, "R10 hold",
                    {prod_hi, prod_lo, carry, zero}, last_out);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 32'd0, 32'd1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        chk({done, prod_hi, prod_lo, carry, zero} == 19'd0, "R12 reset",
            {done, prod_hi, prod_lo, carry, zero}, 0);
        mon_on = 1'b1;

        // R7: -1 x -1 fractional signed wraps
        single(3'd5, 8'h80, 8'h80, "R7 wrap");
        // R1 corners
        single(3'd0, 8'hFF, 8'hFF, "R1 max");
        single(3'd0, 8'h00, 8'h5A, "R1 R6 zero");
        // R2 corners
        single(3'd1, 8'h80, 8'h7F, "R2 min*max");
        single(3'd1, 8'hFF, 8'hFF, "R2 -1*-1");
        // R3: A signed, B unsigned
        single(3'd2, 8'hFF, 8'hFF, "R3 -1*255");
        single(3'd2, 8'h7F, 8'h80, "R3 127*128");
        // R4 / R5 fractional
        single(3'd5, 8'h80, 8'h40, "R4 R5 -1*0.5");
        single(3'd4, 8'h80, 8'h80, "R4 frac unsigned");
        single(3'd6, 8'h80, 8'hFF, "R4 frac mixed");
        // R11 reserved codes
        single(3'd3, 8'hC3, 8'h9E, "R11 code3");
        single(3'd7, 8'hC3, 8'h9E, "R11 code7");

        // R9: start held high over 4 sampling edges; middle two ignored
        @(negedge clk);
        drive(3'd1, 8'h12, 8'h34, 1'b1, "R9 first");
        @(negedge clk);
        drive(3'd0, 8'hAA, 8'hBB, 1'b0, "");
        @(negedge clk);
        drive(3'd4, 8'h55, 8'h66, 1'b0, "");
        @(negedge clk);
        drive(3'd2, 8'h9C, 8'h21, 1'b1, "R9 fourth");
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);

        // Sweep every mode code over strided operands
        for (int m = 0; m < 8; m++) begin
            for (int a = 0; a < 256; a += 15) begin
                for (int b = 0; b < 256; b += 15) begin
                    single(3'(m), 8'(a), 8'(b), mode_tag(3'(m)));
                end
            end
        end

        repeat (6) @(negedge clk);
        chk(sb.size() == 0, "R8 R9 pending", sb.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule